// File: doc/BRIEF.md
# Slow Clock Source Switch Sequencer

This block decides which oscillator drives a low-frequency slow clock. After a power-on reset the on-chip RC oscillator runs the clock and the crystal oscillator stays disabled. Software issues a single command to move the slow clock onto the crystal. The block then runs a fixed series of steps. It hands the oscillator pins to the crystal cell and enables the crystal amplifier. It waits out the crystal start-up time, counted in RC clock periods. It moves the slow clock over to the crystal without a glitch, and finally powers the RC oscillator down.

The change goes one way only. Once the crystal drives the clock, no register write can bring the RC oscillator back. Only a reset of the supply domain does that. A bypass input lets an external square-wave clock take the crystal's place: the sequence is the same, except that the crystal amplifier is never enabled and the external clock goes straight to the clock selector.

Top module: `slck_src_seq`

## Requirements
- R1: While `rst_n` is low, and until a command is accepted, `rc_osc_en`=1, `xo_osc_en`=0, `pin_osc_mode`=0, `sw_done`=0, and `slck` follows `rc_clk`.
- R2: A cycle with `wr_en`=1 and `wr_data[0]`=1 (the crystal-select bit) starts the sequence. A write with `wr_data[0]`=0 changes no output, whatever the other data bits hold.
- R3: `pin_osc_mode` rises first, one cycle after the accepted write. `xo_osc_en` rises on the following `rc_clk` cycle. `rc_osc_en` falls last.
- R4: At least `STARTUP_CYC` `rc_clk` cycles pass between the rise of `xo_osc_en` and the moment the crystal clock is gated onto `slck`.
- R5: The handover is glitch-free. The two clock gates are never open together, and `slck` never shows a high or low pulse shorter than the shorter half-period of the two source clocks.
- R6: `sw_done` rises once the crystal clock is on `slck`, in the same cycle that `rc_osc_en` falls. From then on `slck` follows `xo_clk`.
- R7: After `sw_done`, further writes of either value of the select bit change no output. The state holds until `rst_n` is asserted.
- R8: A second select command that arrives while the sequence is running is ignored and does not restart the start-up wait.
- R9: With `bypass`=1, `xo_osc_en` stays 0 for the whole sequence, and after the switch `slck` follows the external clock on `xo_clk`.
- R10: Asserting `rst_n` after a completed switch returns every output to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | RC oscillator clock; it also clocks the sequencer and the register write |
| xo_clk | input | 1 | Crystal oscillator output, or the external clock when in bypass |
| rst_n | input | 1 | Supply-domain power-on reset, asynchronous, active low |
| wr_en | input | 1 | Control register write strobe, one `rc_clk` cycle |
| wr_data | input | DATA_W | Control register write data; bit 0 selects the crystal |
| bypass | input | 1 | Mode bit: an external clock replaces the crystal resonator |
| slck | output | 1 | Selected slow clock |
| rc_osc_en | output | 1 | RC oscillator enable |
| xo_osc_en | output | 1 | Crystal amplifier enable |
| pin_osc_mode | output | 1 | Gives the oscillator pins to the crystal cell instead of general I/O |
| sw_done | output | 1 | Status: the switch to the crystal is complete |

## Verification
The checker tests every cycle that the two clock gates are never open together. It also checks that the pins are handed over before the crystal is enabled, that the pin and done flags never fall outside reset, that completion coincides with the RC oscillator being off and the crystal gate open, and that the crystal gate opens no earlier than the start-up count allows. Only the bench scenarios can show the rest. These are the exact cycle spacing between the steps, that writes with the select bit clear (or arriving mid-sequence, or after completion) leave the outputs alone, the measured pulse widths on `slck`, which source `slck` follows, and the bypass run with the amplifier left off.

// File: rtl/slck_pkg.sv
package slck_pkg;
  typedef enum logic [2:0] {
    ST_RC   = 3'd0,
    ST_PIN  = 3'd1,
    ST_XEN  = 3'd2,
    ST_WAIT = 3'd3,
    ST_SWAP = 3'd4,
    ST_XTAL = 3'd5
  } seq_state_e;
endpackage

// File: rtl/slck_rst_sync.sv
module slck_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/slck_seq.sv
module slck_seq #(
  parameter int STARTUP_CYC = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_xsel,
  input  logic bypass,
  input  logic xo_on,
  output logic sel_xo,
  output logic pin_osc_mode,
  output logic xo_osc_en,
  output logic rc_osc_en,
  output logic sw_done
);
  import slck_pkg::*;

  localparam int CNT_W = $clog2(STARTUP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYC - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_RC:   if (cmd_xsel) state_d = ST_PIN;
      ST_PIN:  state_d = ST_XEN;
      ST_XEN: begin
        state_d = ST_WAIT;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_SWAP;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_SWAP: if (xo_on) state_d = ST_XTAL;
      ST_XTAL: state_d = ST_XTAL;
      default: state_d = ST_RC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RC;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  logic xo_stage;
  assign xo_stage     = (state_q inside {ST_XEN, ST_WAIT, ST_SWAP, ST_XTAL});
  assign pin_osc_mode = (state_q != ST_RC);
  assign xo_osc_en    = xo_stage & ~bypass;
  assign sel_xo       = (state_q inside {ST_SWAP, ST_XTAL});
  assign rc_osc_en    = (state_q != ST_XTAL);
  assign sw_done      = (state_q == ST_XTAL);
endmodule

// File: rtl/slck_gf_mux.sv
module slck_gf_mux (
  input  logic rc_clk,
  input  logic rc_rst_n,
  input  logic xo_clk,
  input  logic xo_rst_n,
  input  logic sel_xo,
  output logic slck,
  output logic xo_on,
  output logic gate_rc,
  output logic gate_xo
);
  logic rc_s1_q, rc_s2_q;
  logic xo_s1_q, xo_s2_q;
  logic ack_s1_q, ack_s2_q;
  logic rc_req, xo_req;

  assign rc_req = ~sel_xo & ~gate_xo;
  assign xo_req =  sel_xo & ~gate_rc;

  always_ff @(posedge rc_clk or negedge rc_rst_n) begin
    if (!rc_rst_n) begin
      rc_s1_q <= 1'b1;
      rc_s2_q <= 1'b1;
    end else begin
      rc_s1_q <= rc_req;
      rc_s2_q <= rc_s1_q;
    end
  end

  always_ff @(negedge rc_clk or negedge rc_rst_n) begin
    if (!rc_rst_n) gate_rc <= 1'b1;
    else           gate_rc <= rc_s2_q;
  end

  always_ff @(posedge xo_clk or negedge xo_rst_n) begin
    if (!xo_rst_n) begin
      xo_s1_q <= 1'b0;
      xo_s2_q <= 1'b0;
    end else begin
      xo_s1_q <= xo_req;
      xo_s2_q <= xo_s1_q;
    end
  end

  always_ff @(negedge xo_clk or negedge xo_rst_n) begin
    if (!xo_rst_n) gate_xo <= 1'b0;
    else           gate_xo <= xo_s2_q;
  end

  always_ff @(posedge rc_clk or negedge rc_rst_n) begin
    if (!rc_rst_n) begin
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      ack_s1_q <= gate_xo;
      ack_s2_q <= ack_s1_q;
    end
  end

  assign xo_on = ack_s2_q;
  assign slck  = (rc_clk & gate_rc) | (xo_clk & gate_xo);
endmodule

// File: rtl/slck_src_seq.sv
module slck_src_seq #(
  parameter int DATA_W      = 8,
  parameter int STARTUP_CYC = 2048
) (
  input  logic              rc_clk,
  input  logic              xo_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bypass,
  output logic              slck,
  output logic              rc_osc_en,
  output logic              xo_osc_en,
  output logic              pin_osc_mode,
  output logic              sw_done
);
  logic rc_rst_n, xo_rst_n;
  logic sel_xo, xo_on;
  logic gate_rc, gate_xo;
  logic cmd_xsel;
  logic wr_unused;

  assign cmd_xsel  = wr_en & wr_data[0];
  assign wr_unused = ^wr_data;

  slck_rst_sync #(.STAGES(2)) u_rst_rc (
    .clk(rc_clk), .arst_n(rst_n), .srst_n(rc_rst_n)
  );

  slck_rst_sync #(.STAGES(2)) u_rst_xo (
    .clk(xo_clk), .arst_n(rst_n), .srst_n(xo_rst_n)
  );

  slck_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
    .clk          (rc_clk),
    .rst_n        (rc_rst_n),
    .cmd_xsel     (cmd_xsel),
    .bypass       (bypass),
    .xo_on        (xo_on),
    .sel_xo       (sel_xo),
    .pin_osc_mode (pin_osc_mode),
    .xo_osc_en    (xo_osc_en),
    .rc_osc_en    (rc_osc_en),
    .sw_done      (sw_done)
  );

  slck_gf_mux u_mux (
    .rc_clk   (rc_clk),
    .rc_rst_n (rc_rst_n),
    .xo_clk   (xo_clk),
    .xo_rst_n (xo_rst_n),
    .sel_xo   (sel_xo),
    .slck     (slck),
    .xo_on    (xo_on),
    .gate_rc  (gate_rc),
    .gate_xo  (gate_xo)
  );
endmodule

// File: rtl/slck_src_seq_chk.sv
module slck_src_seq_chk #(
  parameter int STARTUP_CYC = 2048
) (
  input logic rc_clk,
  input logic rst_n,
  input logic pin_osc_mode,
  input logic xo_osc_en,
  input logic rc_osc_en,
  input logic sw_done,
  input logic gate_rc,
  input logic gate_xo
);
  localparam int SAT   = STARTUP_CYC + 2;
  localparam int CHK_W = $clog2(SAT + 1) + 1;

  logic [CHK_W-1:0] since_pin_q;

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n)                                    since_pin_q <= '0;
    else if (pin_osc_mode && since_pin_q < CHK_W'(SAT)) since_pin_q <= since_pin_q + 1'b1;
  end

  // R1
  rst_state_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    !pin_osc_mode |-> (rc_osc_en && !sw_done && !xo_osc_en));

  // R3
  pin_first_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    xo_osc_en |-> pin_osc_mode);

  // R4
  wait_min_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    gate_xo |-> (since_pin_q > CHK_W'(STARTUP_CYC)));

  // R5
  gate_excl_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    !(gate_rc && gate_xo));

  // R6
  done_rcoff_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    sw_done |-> (!rc_osc_en && gate_xo && !gate_rc));

  // R7
  done_keep_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    sw_done |=> sw_done);

  // R7
  pin_keep_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    pin_osc_mode |=> pin_osc_mode);
endmodule

bind slck_src_seq slck_src_seq_chk #(.STARTUP_CYC(STARTUP_CYC)) u_chk (
  .rc_clk       (rc_clk),
  .rst_n        (rst_n),
  .pin_osc_mode (pin_osc_mode),
  .xo_osc_en    (xo_osc_en),
  .rc_osc_en    (rc_osc_en),
  .sw_done      (sw_done),
  .gate_rc      (gate_rc),
  .gate_xo      (gate_xo)
);

// File: tb/sim_slck_src_seq.sv
`timescale 1ns/100ps
module sim_slck_src_seq;
  localparam int DW = 8;
  localparam int SC = 64;

  logic rc_clk, xo_clk, rst_n, wr_en, bypass;
  logic [DW-1:0] wr_data;
  logic slck, rc_osc_en, xo_osc_en, pin_osc_mode, sw_done;

  int checks = 0;
  int errors = 0;

  slck_src_seq #(.DATA_W(DW), .STARTUP_CYC(SC)) u0 (
    .rc_clk(rc_clk), .xo_clk(xo_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .bypass(bypass), .slck(slck), .rc_osc_en(rc_osc_en),
    .xo_osc_en(xo_osc_en), .pin_osc_mode(pin_osc_mode), .sw_done(sw_done)
  );

  initial begin rc_clk = 1'b0; forever #5 rc_clk = ~rc_clk; end
  initial begin xo_clk = 1'b0; #1; forever #7 xo_clk = ~xo_clk; end

  typedef struct packed {
    logic [3:0]  tup;   // {pin_osc_mode, xo_osc_en, rc_osc_en, sw_done}
    int unsigned gmin;
    int unsigned gmax;
    logic [15:0] tag;
  } exp_t;

  exp_t exp_q[$];
  logic mon_en = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [15:0] tag,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] t, input int unsigned lo,
                      input int unsigned hi, input logic [15:0] tag);
    exp_t e;
    e.tup = t; e.gmin = lo; e.gmax = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge rc_clk); wr_en = 1'b1; wr_data = d;
    @(negedge rc_clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // scoreboard monitor: every change of the status tuple pops one expected item
  int unsigned cyc = 0, last_cyc = 0;
  logic [3:0] prev_t;
  always @(negedge rc_clk) begin
    logic [3:0] cur;
    exp_t e;
    int unsigned gap;
    cur = {pin_osc_mode, xo_osc_en, rc_osc_en, sw_done};
    cyc++;
    if (!mon_en) begin
      prev_t   = cur;
      last_cyc = cyc;
    end else if (cur != prev_t) begin
      gap = cyc - last_cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected status change", "R3", int'(cur), int'(prev_t));
      end else begin
        e = exp_q.pop_front();
        chk(cur == e.tup, "status step value", e.tag, int'(cur), int'(e.tup));
        chk(gap >= e.gmin && gap <= e.gmax, "step spacing in cycles", e.tag,
            int'(gap), int'(e.gmin));
      end
      prev_t   = cur;
      last_cyc = cyc;
    end
  end

  // pulse width monitor on slck (R5)
  realtime last_edge = 0.0, min_pulse = 1000.0;
  bit seen_edge = 1'b0;
  always @(slck) begin
    if (!mon_en) begin
      seen_edge = 1'b0;
    end else begin
      if (seen_edge && ($realtime - last_edge) < min_pulse) min_pulse = $realtime - last_edge;
      last_edge = $realtime;
      seen_edge = 1'b1;
    end
  end

  task automatic follow(input bit exp_xo, input logic [15:0] tag);
    int bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge rc_clk); #2.5;
      if (slck !== (exp_xo ? xo_clk : rc_clk)) bad++;
      #1.3;
      if (slck !== (exp_xo ? xo_clk : rc_clk)) bad++;
    end
    chk(bad == 0, exp_xo ? "slck follows xo_clk" : "slck follows rc_clk", tag, bad, 0);
  endtask

  task automatic chk_outs(input logic [3:0] exp, input string what, input logic [15:0] tag);
    logic [3:0] act;
    act = {pin_osc_mode, xo_osc_en, rc_osc_en, sw_done};
    chk(act === exp, what, tag, int'(act), int'(exp));
  endtask

  task automatic wait_done(input logic [15:0] tag);
    int n = 0;
    while (!sw_done && n < 4 * SC + 200) begin @(negedge rc_clk); n++; end
    chk(sw_done === 1'b1, "sw_done reached", tag, int'(sw_done), 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; bypass = 1'b0;
    #43;
    chk_outs(4'b0010, "outputs during reset", "R1");
    @(negedge rc_clk); rst_n = 1'b1;
    repeat (4) @(negedge rc_clk);
    mon_en = 1'b1;
    chk_outs(4'b0010, "outputs after reset", "R1");
    follow(1'b0, "R1");

    // select bit clear: ignored
    wr(8'h00);
    wr(8'hFE);
    repeat (8) @(negedge rc_clk);
    chk_outs(4'b0010, "write with bit0=0 ignored", "R2");
    chk(exp_q.size() == 0, "no pending steps after ignored write", "R2", exp_q.size(), 0);

    // start the switch, crystal mode
    push(4'b1010, 0, 100000, "R2");
    push(4'b1110, 1, 1, "R3");
    push(4'b1101, SC + 1, SC + 21, "R4");
    wr(8'h01);
    repeat (30) @(negedge rc_clk);
    chk_outs(4'b1110, "mid-wait state", "R3");
    wr(8'h01);  // second command mid-sequence: must not restart the wait (R8)
    wait_done("R6");
    repeat (2) @(negedge rc_clk);
    chk(exp_q.size() == 0, "all steps seen in order", "R8", exp_q.size(), 0);
    chk_outs(4'b1101, "final state crystal", "R6");
    follow(1'b1, "R6");

    // one-way: later writes ignored
    wr(8'h01);
    wr(8'h00);
    repeat (10) @(negedge rc_clk);
    chk_outs(4'b1101, "writes after switch ignored", "R7");
    follow(1'b1, "R7");
    chk(min_pulse >= 4.99, "minimum slck pulse (x10 ns/10)", "R5", int'(min_pulse * 10), 50);

    // power cycle back to RC
    mon_en = 1'b0;
    @(negedge rc_clk); rst_n = 1'b0;
    #1;
    chk_outs(4'b0010, "reset after switch", "R10");
    repeat (3) @(negedge rc_clk); rst_n = 1'b1; bypass = 1'b1;
    repeat (4) @(negedge rc_clk);
    mon_en = 1'b1;
    chk_outs(4'b0010, "state after second reset", "R10");
    follow(1'b0, "R10");

    // bypass run
    push(4'b1010, 0, 100000, "R9");
    push(4'b1001, SC + 2, SC + 22, "R9");
    wr(8'h81);
    repeat (20) @(negedge rc_clk);
    chk(xo_osc_en === 1'b0, "crystal amp stays off in bypass", "R9", int'(xo_osc_en), 0);
    wait_done("R9");
    repeat (2) @(negedge rc_clk);
    chk(exp_q.size() == 0, "bypass steps seen", "R9", exp_q.size(), 0);
    chk_outs(4'b1001, "bypass final state", "R9");
    follow(1'b1, "R9");
    chk(min_pulse >= 4.99, "minimum slck pulse bypass (x10 ns/10)", "R5", int'(min_pulse * 10), 50);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule